// File: doc/BRIEF.md
# On-Demand Sample Frame Capture Gate

This block sits between a free-running receive sample stream and a downstream frame consumer such as a transform engine. The sample source runs without pause, and by default every sample is discarded. A processor writes a one-bit request control value. When that value goes from low to high, the gate captures the next `FRAME_LEN` valid samples and sends them out as a single framed burst on a valid/ready stream. The final beat carries a last marker. The gate then goes back to discarding samples. Requests can arrive at any time relative to the sample cadence, and they do not change the sample rate.

The input side has no back-pressure: a sample offered while the gate cannot take it is lost. On the output side, a beat stays on the port with data and last held steady until `m_ready` accepts it. If the output holding register is still full and stalled when a new valid sample arrives, that sample is dropped. It does not count toward the frame, and a sticky error bit is set, so a stalled frame still ends up with `FRAME_LEN` beats in order. The processor learns that a frame is complete by polling plain status pins. The gate raises no interrupt.

Top module: `frame_capture_gate`

## Requirements
- R1: A capture starts only in the cycle where `cap_req` is 1 and was 0 in the previous cycle. Holding `cap_req` high starts no further captures.
- R2: A capture delivers exactly `FRAME_LEN` beats. They are the first `FRAME_LEN` samples with `s_valid`=1, taken from the cycles after the cycle in which the rising edge is seen. Cycles with `s_valid`=0 are skipped.
- R3: `m_last` is 1 on the `FRAME_LEN`-th beat of a frame and 0 on every earlier beat.
- R4: While no capture is running, `m_valid` is 0 and no input sample reaches the output.
- R5: While `m_valid`=1 and `m_ready`=0, the outputs `m_valid`, `m_data` and `m_last` hold their values. A valid sample that arrives while the output register is full and stalled is dropped and not counted, and `stat_drop_err` is set. An accepted request clears `stat_drop_err`.
- R6: `stat_busy` goes to 1 in the cycle after an accepted edge and returns to 0 after the last beat's handshake. `stat_done` is sticky: it is set by that handshake and cleared by the next accepted request.
- R7: A rising edge that arrives while `stat_busy`=1 is ignored, and the sticky `stat_overrun` bit is set. The next accepted request clears `stat_overrun`.
- R8: If `cap_req` is already 1 when reset is released, no capture starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | DATA_W | Incoming sample |
| s_valid | input | 1 | Sample present this cycle (no back-pressure) |
| cap_req | input | 1 | Processor-written request level |
| m_data | output | DATA_W | Framed output sample |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Downstream accepts beat |
| m_last | output | 1 | Final beat of the frame |
| stat_busy | output | 1 | Capture or drain in progress |
| stat_done | output | 1 | Sticky: last beat delivered |
| stat_overrun | output | 1 | Sticky: edge ignored while busy |
| stat_drop_err | output | 1 | Sticky: sample lost to output stall |

## Verification
The hardest case to reach is a sample lost because the output register is stalled. It needs a full holding register, a low `m_ready` and a valid input sample, all in the same cycle of an active capture. The bench issues a request with the input valid every cycle, then holds `m_ready` low for three cycles right after the first accepted beat. From this it works out which sample indices must be skipped, and it checks that the held beat stays stable. Overrun is reached by pulsing the request low and then high again while a slowly fed frame is still in progress.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [1:0] {
    FCG_IDLE  = 2'd0,
    FCG_CAPT  = 2'd1,
    FCG_DRAIN = 2'd2
  } fcg_state_e;
endpackage

// File: rtl/fcg_edge_detect.sv
module fcg_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  // History resets to 1 so a level already high at reset is not an edge.
  logic hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 1'b1;
    else        hist_q <= level_i;
  end

  assign rise_o = level_i & ~hist_q;

  AST_LEVEL_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && $past(level_i)) |-> !rise_o); // R1
endmodule

// File: rtl/fcg_frame_counter.sv
module fcg_frame_counter #(
  parameter int FRAME_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic final_o
);
  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_q <= '0;
    else if (step_i) begin
      if (cnt_q == LAST_IDX) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign final_o = (cnt_q == LAST_IDX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && final_o && !clear_i) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/fcg_out_stage.sv
module fcg_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  output logic              room_o,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_last
);
  assign room_o = ~m_valid | m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (load_i) begin
      m_valid <= 1'b1;
      m_data  <= data_i;
      m_last  <= last_i;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R5
endmodule

// File: rtl/frame_capture_gate.sv
module frame_capture_gate
  import fcg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              cap_req,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_last,
  output logic              stat_busy,
  output logic              stat_done,
  output logic              stat_overrun,
  output logic              stat_drop_err
);
  fcg_state_e state_q;
  logic req_rise, room, cnt_final;
  logic idle, start_ok, accept, stall_drop, last_hs;

  fcg_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (cap_req),
    .rise_o  (req_rise)
  );

  assign idle       = (state_q == FCG_IDLE);
  assign start_ok   = req_rise & idle;
  assign accept     = (state_q == FCG_CAPT) & s_valid & room;
  assign stall_drop = (state_q == FCG_CAPT) & s_valid & ~room;
  assign last_hs    = m_valid & m_ready & m_last;

  fcg_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_ok),
    .step_i  (accept),
    .final_o (cnt_final)
  );

  fcg_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .data_i  (s_data),
    .last_i  (cnt_final),
    .room_o  (room),
    .m_data  (m_data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_last  (m_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FCG_IDLE;
    else begin
      unique case (state_q)
        FCG_IDLE:  if (req_rise)              state_q <= FCG_CAPT;
        FCG_CAPT:  if (accept && cnt_final)   state_q <= FCG_DRAIN;
        FCG_DRAIN: if (last_hs)               state_q <= FCG_IDLE;
        default:                              state_q <= FCG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_done     <= 1'b0;
      stat_overrun  <= 1'b0;
      stat_drop_err <= 1'b0;
    end else if (start_ok) begin
      stat_done     <= 1'b0;
      stat_overrun  <= 1'b0;
      stat_drop_err <= 1'b0;
    end else begin
      if (last_hs)    stat_done     <= 1'b1;
      if (req_rise)   stat_overrun  <= 1'b1;
      if (stall_drop) stat_drop_err <= 1'b1;
    end
  end

  assign stat_busy = ~idle;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> !m_valid); // R4
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && !stat_busy) |=> (stat_busy && !stat_done)); // R6
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> (stat_done && !stat_busy)); // R6
  AST_OVERRUN_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && stat_busy) |=> stat_overrun); // R7
  AST_DROP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_busy && s_valid && m_valid && !m_ready && !(m_last && m_valid)) |=> stat_drop_err); // R5
endmodule

// File: tb/frame_capture_gate_tb.sv
`timescale 1ns/1ps
module frame_capture_gate_tb;
  localparam int DW = 16;
  localparam int N  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_valid = 1'b0, cap_req = 1'b0, m_ready = 1'b1;
  logic [DW-1:0] m_data;
  logic m_valid, m_last, stat_busy, stat_done, stat_overrun, stat_drop_err;

  always #2.5 clk = ~clk;

  frame_capture_gate #(.DATA_W(DW), .FRAME_LEN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
    .cap_req(cap_req), .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_last(m_last), .stat_busy(stat_busy), .stat_done(stat_done),
    .stat_overrun(stat_overrun), .stat_drop_err(stat_drop_err)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nbeat = 0, ecount = 0;
  bit track = 0;
  int got [0:15];
  bit gotlast [0:15];
  int expv [0:15];

  task automatic check(input bit ok, input string rq, input int act, input int exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exv);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Drive inputs after the falling edge, then observe registered outputs.
  task automatic drive_cycle(input bit rq, input bit sv, input bit mr);
    @(negedge clk);
    if (track && sv && ecount < N) begin
      expv[ecount] = cyc;
      ecount++;
    end
    cap_req = rq; s_valid = sv; m_ready = mr; s_data = DW'(cyc);
    cyc++;
    #1;
    if (m_valid && m_ready) begin
      if (nbeat < 16) begin
        got[nbeat] = int'(m_data);
        gotlast[nbeat] = m_last;
      end
      nbeat++;
    end
  endtask

  task automatic check_frame(input string tag);
    check(nbeat == N, {tag, " R2 beat count"}, nbeat, N);
    for (int i = 0; i < N; i++) begin
      check(got[i] == (expv[i] & 16'hFFFF), {tag, " R2 beat data"}, got[i], expv[i]);
      check(gotlast[i] == (i == N - 1), {tag, " R3 last flag"}, gotlast[i], i == N - 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    // R8: request already high while reset is applied
    cap_req = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!m_valid, "R4 reset m_valid", m_valid, 0);
    check(!stat_busy && !stat_done && !stat_overrun && !stat_drop_err,
          "R6 reset status", {stat_busy, stat_done, stat_overrun, stat_drop_err}, 0);
    nbeat = 0;
    for (int k = 0; k < 15; k++) drive_cycle(1, 1, 1);
    check(nbeat == 0, "R8 no capture from level at reset", nbeat, 0);
    check(!stat_busy, "R8 idle after reset with high request", stat_busy, 0);

    // R1/R2/R3/R6: sweep of all nonzero 4-cycle valid patterns
    for (int p = 1; p < 16; p++) begin
      nbeat = 0; ecount = 0; track = 0;
      for (int k = 0; k < 3; k++) drive_cycle(0, p[cyc % 4], 1);
      check(nbeat == 0, "R4 no output before request", nbeat, 0);
      drive_cycle(1, p[cyc % 4], 1);
      track = 1;
      drive_cycle(1, p[cyc % 4], 1);
      check(stat_busy == 1, "R6 busy after edge", stat_busy, 1);
      check(stat_done == 0, "R6 done cleared by request", stat_done, 0);
      for (int k = 0; k < 40; k++) drive_cycle(k < 20, p[cyc % 4], 1);
      track = 0;
      check_frame("sweep");
      check(stat_done && !stat_busy, "R6 done and idle after frame", {stat_done, stat_busy}, 2);
      check(!stat_drop_err, "R5 no drop without stall", stat_drop_err, 0);
    end

    // R5: stall right after first accepted beat, input valid every cycle
    begin
      int base;
      nbeat = 0; track = 0;
      drive_cycle(0, 1, 1);
      drive_cycle(0, 1, 1);
      drive_cycle(1, 1, 1);
      base = cyc;
      drive_cycle(1, 1, 0);
      drive_cycle(1, 1, 0);
      check(m_valid && int'(m_data) == base, "R5 held beat during stall", int'(m_data), base);
      drive_cycle(1, 1, 0);
      check(m_valid && int'(m_data) == base, "R5 held beat during stall", int'(m_data), base);
      drive_cycle(1, 1, 1);
      check(m_valid && int'(m_data) == base, "R5 beat released on ready", int'(m_data), base);
      for (int k = 0; k < 10; k++) drive_cycle(1, 1, 1);
      expv[0] = base; expv[1] = base + 3; expv[2] = base + 4; expv[3] = base + 5;
      check_frame("stall");
      check(stat_drop_err == 1, "R5 drop error set", stat_drop_err, 0 + 1);
      check(stat_done == 1, "R6 done after stalled frame", stat_done, 1);
    end

    // R7: second edge during a slow frame is ignored
    nbeat = 0; ecount = 0; track = 0;
    drive_cycle(0, cyc[0], 1);
    drive_cycle(1, cyc[0], 1);
    track = 1;
    drive_cycle(0, cyc[0], 1);
    check(stat_drop_err == 0, "R5 drop error cleared by request", stat_drop_err, 0);
    drive_cycle(1, cyc[0], 1);
    for (int k = 0; k < 30; k++) drive_cycle(1, cyc[0], 1);
    track = 0;
    check_frame("overrun");
    check(stat_overrun == 1, "R7 overrun set", stat_overrun, 1);
    for (int k = 0; k < 20; k++) drive_cycle(1, 1, 1);
    check(nbeat == N, "R1 held level starts nothing", nbeat, N);
    nbeat = 0; ecount = 0;
    drive_cycle(0, 1, 1);
    drive_cycle(1, 1, 1);
    track = 1;
    drive_cycle(1, 1, 1);
    check(stat_overrun == 0, "R7 overrun cleared by request", stat_overrun, 0);
    for (int k = 0; k < 12; k++) drive_cycle(0, 1, 1);
    track = 0;
    check_frame("final");
    check(stat_done && !stat_busy, "R6 final done", {stat_done, stat_busy}, 2);

    report();
    $finish;
  end
endmodule